// File: doc/BRIEF.md
# Receive Sample Packet Framer

This block groups a stream of received sample words into framed packets on a 32-bit word stream that carries start-of-packet and end-of-packet flags. Each sample time delivers one input word per active channel. When a packet is complete, the framer sends a fixed prologue followed by the buffered samples and a closing word. The prologue is a header word, a stream identifier word, one whole-seconds word and two tick words (upper half first). The closing word is a programmable trailer.

The upper header bits are the host's own indicator bits. The framer inserts two things into the lower bits itself: a rolling 4-bit packet number and the total packet length in words. Because the length must be known before the header leaves, the payload is first collected in an internal buffer. While a packet is being sent, the input is held off. Input back-pressure follows these rules: `s_ready` is high only while a packet is being filled, and a word transfers on a clock edge where `s_valid` and `s_ready` are both high. Output back-pressure follows these rules: a word transfers on an edge where `m_valid` and `m_ready` are both high. While `m_ready` is low, `m_valid`, `m_data`, `m_sop` and `m_eop` hold their values.

Top module: `rx_pkt_framer`

## Requirements
- R1: After reset, `m_valid` is 0, `s_ready` is 1, and the first packet carries packet number 0.
- R2: A packet is sent in this order: header, stream-ID word, seconds word, ticks bits 63:32, ticks bits 31:0, the payload words in arrival order, and the trailer word. `m_sop` is set only on the header and `m_eop` only on the trailer.
- R3: Header bits 31:20 come from the host header register, bits 19:16 hold the packet number, and bits 15:0 hold the total word count, which is the payload count plus 6.
- R4: A packet closes once the payload count reaches samples-per-packet times channel-count.
- R5: In the channel-count register, a value of 0 acts as 1 and a value above 4 acts as 4. In the samples-per-packet register, 0 acts as 1 and a value above 64 acts as 64. Both registers use bits 15:0 of the written word.
- R6: An accepted input word with `s_last` set closes a short packet at once, with a correct length field and the trailer appended.
- R7: The seconds and ticks words are the values of `time_secs` and `time_ticks` at the edge where the packet's first payload word is accepted.
- R8: The packet number rises by one per packet, modulo 16.
- R9: A write to offset 3 (any data) sets the next packet number to 0. If the write falls on the edge where a packet closes, the closing packet keeps its number and the following packet carries 0.
- R10: While a packet is being sent, `s_ready` is 0. No output word is lost or changed while `m_ready` is low.
- R11: The register offsets are 4 for header, 5 for stream ID, 6 for trailer, 7 for samples-per-packet and 8 for channel-count. Writes to any other offset except 3 change nothing.
- R12: The header, stream-ID and trailer values of a packet are fixed on the edge where it closes. Register writes made while it is being sent take effect from the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| time_secs | input | 32 | Current whole-seconds time |
| time_ticks | input | 64 | Current tick count |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted when high with s_valid |
| s_data | input | 32 | Input sample word (one channel) |
| s_last | input | 1 | Input word ends the stream |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 32 | Output packet word |
| m_sop | output | 1 | Output word is the packet header |
| m_eop | output | 1 | Output word is the trailer |

## Verification
The clear-to-zero write to offset 3 and the packet-number advance at a packet close can land on the same clock edge. The bench provokes this by presenting the last payload word of a packet together with a clear write in the same cycle. The closing packet must still show its old number, and the next packet must show 0; a clear that is lost would instead show the old number plus one. The register snapshot has a similar overlap: header, stream-ID and trailer writes arrive while a closed packet waits with `m_ready` low, and the bench checks that they appear only in the packet after it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int CFG_AW = 4;
  localparam logic [CFG_AW-1:0] OFS_CLR = 4'd3;
  localparam logic [CFG_AW-1:0] OFS_HDR = 4'd4;
  localparam logic [CFG_AW-1:0] OFS_SID = 4'd5;
  localparam logic [CFG_AW-1:0] OFS_TRL = 4'd6;
  localparam logic [CFG_AW-1:0] OFS_SPP = 4'd7;
  localparam logic [CFG_AW-1:0] OFS_NCH = 4'd8;

  localparam int WORD_W      = 32;
  localparam int CNT_W       = 4;
  localparam int LEN_W       = 16;
  localparam int KEEP_LSB    = LEN_W + CNT_W;
  localparam int KEEP_W      = WORD_W - KEEP_LSB;
  localparam int FIXED_WORDS = 6;

  typedef enum logic [2:0] {
    ST_FILL, ST_HDR, ST_SID, ST_SEC, ST_THI, ST_TLO, ST_PAY, ST_TRL
  } frm_state_e;
endpackage

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int MAX_CH    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [WORD_W-1:0]    cfg_wdata,
  input  logic                 pkt_close,
  output logic [KEEP_W-1:0]    hdr_keep,
  output logic [WORD_W-1:0]    sid_word,
  output logic [WORD_W-1:0]    trl_word,
  output logic [$clog2(BUF_DEPTH):0] tgt_words,
  output logic [CNT_W-1:0]     pkt_cnt
);
  localparam int SPP_MAX = BUF_DEPTH / MAX_CH;
  localparam int CW      = $clog2(BUF_DEPTH) + 1;
  localparam int CHW     = $clog2(MAX_CH + 1);

  logic [15:0]    spp_q, nch_q;
  logic [CW-1:0]  spp_eff;
  logic [CHW-1:0] nch_eff;
  logic           clr_hit;

  assign clr_hit = cfg_we && (cfg_addr == OFS_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_keep <= '0;
      sid_word <= '0;
      trl_word <= '0;
      spp_q    <= 16'd1;
      nch_q    <= 16'd1;
    end else if (cfg_we) begin
      case (cfg_addr)
        OFS_HDR: hdr_keep <= cfg_wdata[WORD_W-1:KEEP_LSB];
        OFS_SID: sid_word <= cfg_wdata;
        OFS_TRL: trl_word <= cfg_wdata;
        OFS_SPP: spp_q    <= cfg_wdata[15:0];
        OFS_NCH: nch_q    <= cfg_wdata[15:0];
        default: ;
      endcase
    end
  end

  // packet number: clear wins over the advance of a closing packet
  always_ff @(posedge clk) begin
    if (rst)            pkt_cnt <= '0;
    else if (clr_hit)   pkt_cnt <= '0;
    else if (pkt_close) pkt_cnt <= pkt_cnt + CNT_W'(1);
  end

  always_comb begin
    if (spp_q == 16'd0)                spp_eff = CW'(1);
    else if (spp_q > 16'(SPP_MAX))     spp_eff = CW'(SPP_MAX);
    else                               spp_eff = spp_q[CW-1:0];
    if (nch_q == 16'd0)                nch_eff = CHW'(1);
    else if (nch_q > 16'(MAX_CH))      nch_eff = CHW'(MAX_CH);
    else                               nch_eff = nch_q[CHW-1:0];
  end

  assign tgt_words = spp_eff * CW'(nch_eff);

  assert_cnt_step_R8: assert property (@(posedge clk) disable iff (rst)
    (pkt_close && !clr_hit) |=> (pkt_cnt == CNT_W'($past(pkt_cnt) + CNT_W'(1))));

  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> (pkt_cnt == '0));

  assert_tgt_range_R5: assert property (@(posedge clk) disable iff (rst)
    (tgt_words >= CW'(1)) && (tgt_words <= CW'(BUF_DEPTH)));
endmodule

// File: rtl/rxf_buf.sv
module rxf_buf #(
  parameter int DEPTH = 256,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [W-1:0]             wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [W-1:0]             rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int BUF_DEPTH = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  input  logic                 s_last,
  output logic                 s_ready,
  input  logic                 m_ready,
  output logic                 m_valid,
  output logic [WORD_W-1:0]    m_data,
  output logic                 m_sop,
  output logic                 m_eop,
  input  logic [31:0]          time_secs,
  input  logic [63:0]          time_ticks,
  input  logic [KEEP_W-1:0]    hdr_keep,
  input  logic [WORD_W-1:0]    sid_word,
  input  logic [WORD_W-1:0]    trl_word,
  input  logic [$clog2(BUF_DEPTH):0] tgt_words,
  input  logic [CNT_W-1:0]     pkt_cnt,
  output logic                 pkt_close,
  output logic                 buf_we,
  output logic [$clog2(BUF_DEPTH)-1:0] buf_waddr,
  output logic [$clog2(BUF_DEPTH)-1:0] buf_raddr,
  input  logic [WORD_W-1:0]    buf_rdata
);
  localparam int AW = $clog2(BUF_DEPTH);
  localparam int CW = AW + 1;

  frm_state_e       state;
  logic [CW-1:0]    wcnt, rcnt, nw_q, tgt_q;
  logic [CW-1:0]    wnext, rnext, tgt_use;
  logic [31:0]      secs_q;
  logic [63:0]      ticks_q;
  logic [WORD_W-1:0] hdr_q, sid_q, trl_q;
  logic             take, fill_done;

  assign s_ready   = (state == ST_FILL);
  assign take      = s_valid && s_ready;
  assign wnext     = wcnt + CW'(1);
  assign rnext     = rcnt + CW'(1);
  assign tgt_use   = (wcnt == '0) ? tgt_words : tgt_q;
  assign fill_done = take && (s_last || (wnext == tgt_use));
  assign pkt_close = fill_done;
  assign buf_we    = take;
  assign buf_waddr = wcnt[AW-1:0];
  assign buf_raddr = rcnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FILL;
      wcnt    <= '0;
      rcnt    <= '0;
      nw_q    <= '0;
      tgt_q   <= '0;
      secs_q  <= '0;
      ticks_q <= '0;
      hdr_q   <= '0;
      sid_q   <= '0;
      trl_q   <= '0;
    end else begin
      case (state)
        ST_FILL: if (take) begin
          wcnt <= wnext;
          if (wcnt == '0) begin
            tgt_q   <= tgt_words;
            secs_q  <= time_secs;
            ticks_q <= time_ticks;
          end
          if (fill_done) begin
            state <= ST_HDR;
            nw_q  <= wnext;
            hdr_q <= {hdr_keep, pkt_cnt,
                      LEN_W'(wnext) + LEN_W'(FIXED_WORDS)};
            sid_q <= sid_word;
            trl_q <= trl_word;
          end
        end
        ST_HDR: if (m_ready) state <= ST_SID;
        ST_SID: if (m_ready) state <= ST_SEC;
        ST_SEC: if (m_ready) state <= ST_THI;
        ST_THI: if (m_ready) state <= ST_TLO;
        ST_TLO: if (m_ready) begin
          state <= ST_PAY;
          rcnt  <= '0;
        end
        ST_PAY: if (m_ready) begin
          if (rnext == nw_q) begin
            state <= ST_TRL;
            rcnt  <= '0;
          end else begin
            rcnt <= rnext;
          end
        end
        ST_TRL: if (m_ready) begin
          state <= ST_FILL;
          wcnt  <= '0;
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  always_comb begin
    m_valid = (state != ST_FILL);
    m_sop   = (state == ST_HDR);
    m_eop   = (state == ST_TRL);
    case (state)
      ST_HDR:  m_data = hdr_q;
      ST_SID:  m_data = sid_q;
      ST_SEC:  m_data = secs_q;
      ST_THI:  m_data = ticks_q[63:32];
      ST_TLO:  m_data = ticks_q[31:0];
      ST_PAY:  m_data = buf_rdata;
      ST_TRL:  m_data = trl_q;
      default: m_data = '0;
    endcase
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sop) && $stable(m_eop)));

  assert_no_input_while_sending_R10: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> !s_ready);

  assert_len_field_R3: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_sop) |-> ((m_data[LEN_W-1:0] >= LEN_W'(FIXED_WORDS + 1)) &&
                            (m_data[LEN_W-1:0] <= LEN_W'(FIXED_WORDS + BUF_DEPTH))));

  assert_eop_reopens_R2: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && m_eop) |=> (!m_valid && s_ready));

  assert_close_starts_hdr_R6: assert property (@(posedge clk) disable iff (rst)
    (take && s_last) |=> (m_valid && m_sop));
endmodule

// File: rtl/rx_pkt_framer.sv
module rx_pkt_framer
  import rxf_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int MAX_CH    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [3:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic [31:0] time_secs,
  input  logic [63:0] time_ticks,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_data,
  input  logic        s_last,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [31:0] m_data,
  output logic        m_sop,
  output logic        m_eop
);
  localparam int AW = $clog2(BUF_DEPTH);

  logic [KEEP_W-1:0] hdr_keep;
  logic [31:0]       sid_word, trl_word, buf_rdata;
  logic [AW:0]       tgt_words;
  logic [CNT_W-1:0]  pkt_cnt;
  logic              pkt_close, buf_we;
  logic [AW-1:0]     buf_waddr, buf_raddr;

  rxf_regs #(.BUF_DEPTH(BUF_DEPTH), .MAX_CH(MAX_CH)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pkt_close(pkt_close), .hdr_keep(hdr_keep),
    .sid_word(sid_word), .trl_word(trl_word), .tgt_words(tgt_words),
    .pkt_cnt(pkt_cnt)
  );

  rxf_buf #(.DEPTH(BUF_DEPTH), .W(32)) u_buf (
    .clk(clk), .wr_en(buf_we), .wr_addr(buf_waddr), .wr_data(s_data),
    .rd_addr(buf_raddr), .rd_data(buf_rdata)
  );

  rxf_ctrl #(.BUF_DEPTH(BUF_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .m_ready(m_ready), .m_valid(m_valid),
    .m_data(m_data), .m_sop(m_sop), .m_eop(m_eop),
    .time_secs(time_secs), .time_ticks(time_ticks), .hdr_keep(hdr_keep),
    .sid_word(sid_word), .trl_word(trl_word), .tgt_words(tgt_words),
    .pkt_cnt(pkt_cnt), .pkt_close(pkt_close), .buf_we(buf_we),
    .buf_waddr(buf_waddr), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata)
  );
endmodule

// File: tb/test_rx_pkt_framer.sv
`timescale 1ns/1ps
module test_rx_pkt_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] time_secs;
  logic [63:0] time_ticks;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        s_last = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [31:0] m_data;
  logic        m_sop, m_eop;

  always #2 clk = ~clk;

  rx_pkt_framer i_rx_pkt_framer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .time_secs(time_secs), .time_ticks(time_ticks),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_sop(m_sop), .m_eop(m_eop)
  );

  logic [31:0] cyc = '0;
  always @(posedge clk) cyc <= cyc + 32'd1;
  assign time_secs  = 32'h0000_5000 + cyc;
  assign time_ticks = {cyc * 32'd7 + 32'hA000_0000, ~cyc};

  int nvec = 0, nbad = 0;
  logic [31:0] hdr_m = '0, sid_m = '0, trl_m = '0;
  logic [3:0]  exp_cnt = '0;
  logic [31:0] cap_secs;
  logic [63:0] cap_ticks;
  logic [31:0] sent [0:299];
  logic [31:0] got  [0:299];
  bit          gsop [0:299];
  bit          geop [0:299];
  int          got_n;
  bit          hold_bad, sready_bad;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] d, input logic last, input bit first);
    int g = 0;
    s_valid = 1'b1; s_data = d; s_last = last;
    while (!s_ready && g < 1000) begin @(negedge clk); g++; end
    if (first) begin cap_secs = time_secs; cap_ticks = time_ticks; end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic send(input int n, input bit last, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      sent[i] = base + 32'(i);
      push_word(sent[i], last && (i == n - 1), i == 0);
    end
  endtask

  // mode 0: always ready, 1: every other cycle, 2: stalls of three cycles
  task automatic collect(input int mode);
    int k = 0;
    bit pend = 0, done = 0, rdy;
    logic [31:0] held = '0;
    got_n = 0; hold_bad = 0; sready_bad = 0;
    while (!done && k < 3000) begin
      if (pend && (!m_valid || m_data !== held)) hold_bad = 1;
      if (m_valid && s_ready) sready_bad = 1;
      rdy = (mode == 0) ? 1'b1 : (mode == 1) ? k[0] : ((k % 5) >= 3);
      m_ready = rdy;
      pend = m_valid && !rdy;
      held = m_data;
      if (m_valid && rdy && got_n < 300) begin
        got[got_n] = m_data; gsop[got_n] = m_sop; geop[got_n] = m_eop;
        got_n++;
        if (m_eop) done = 1;
      end
      k++;
      @(negedge clk);
    end
    m_ready = 1'b0;
  endtask

  task automatic check_pkt(input int npay, input string lreq);
    int len = npay + 6;
    bit flags_ok = 1;
    chk(lreq, 32'(got_n), 32'(len), "packet word count");
    chk("R3", got[0], {hdr_m[31:20], exp_cnt, 16'(len)}, "header word");
    chk("R2", got[1], sid_m, "stream id word");
    chk("R7", got[2], cap_secs, "seconds word");
    chk("R7", got[3], cap_ticks[63:32], "ticks high word");
    chk("R7", got[4], cap_ticks[31:0], "ticks low word");
    for (int i = 0; i < npay; i++) chk(lreq, got[5+i], sent[i], "payload word");
    chk("R2", got[len-1], trl_m, "trailer word");
    for (int i = 0; i < got_n; i++)
      if (gsop[i] != (i == 0) || geop[i] != (i == got_n - 1)) flags_ok = 0;
    chk("R2", 32'(flags_ok), 32'd1, "sop/eop placement");
    chk("R10", {30'd0, hold_bad, sready_bad}, 32'd0, "stall hold / input held off");
    exp_cnt = exp_cnt + 4'd1;
  endtask

  task automatic t_reset_R1;
    chk("R1", 32'(m_valid), 32'd0, "m_valid after reset");
    chk("R1", 32'(s_ready), 32'd1, "s_ready after reset");
    hdr_m = 32'h14DF_ABCD; wr(4'd4, hdr_m);
    sid_m = 32'h0000_1234; wr(4'd5, sid_m);
    trl_m = 32'hCAFE_0001; wr(4'd6, trl_m);
    wr(4'd7, 32'd4); wr(4'd8, 32'd1);
    send(4, 0, 32'h1000_0000);
    collect(0);
    chk("R1", 32'(got[0][19:16]), 32'd0, "first packet number");
    check_pkt(4, "R4");
  endtask

  task automatic t_full_R4;
    wr(4'd7, 32'd3); wr(4'd8, 32'd2);
    send(6, 0, 32'h2000_0000);
    collect(1);
    check_pkt(6, "R4");
  endtask

  task automatic t_short_R6;
    wr(4'd7, 32'd8); wr(4'd8, 32'd2);
    send(5, 1, 32'h3000_0000);
    collect(0);
    check_pkt(5, "R6");
  endtask

  task automatic t_clamp_R5;
    wr(4'd7, 32'd2); wr(4'd8, 32'd0);
    send(2, 0, 32'h4000_0000); collect(0); check_pkt(2, "R5");
    wr(4'd8, 32'd7);
    send(8, 0, 32'h4100_0000); collect(0); check_pkt(8, "R5");
    wr(4'd7, 32'd0); wr(4'd8, 32'd1);
    send(1, 0, 32'h4200_0000); collect(0); check_pkt(1, "R5");
    wr(4'd7, 32'd100);
    send(64, 0, 32'h4300_0000); collect(0); check_pkt(64, "R5");
  endtask

  task automatic t_backpressure_R10;
    wr(4'd7, 32'd5); wr(4'd8, 32'd3);
    send(15, 0, 32'h5000_0000);
    collect(2);
    check_pkt(15, "R10");
  endtask

  task automatic t_snapshot_R12;
    logic [31:0] nh = 32'h2A0F_0000, ns = 32'h0000_0077, nt = 32'h1357_9BDF;
    wr(4'd7, 32'd2); wr(4'd8, 32'd1);
    send(2, 0, 32'h6000_0000);
    wr(4'd4, nh); wr(4'd5, ns); wr(4'd6, nt);
    collect(0);
    check_pkt(2, "R12");
    hdr_m = nh; sid_m = ns; trl_m = nt;
    send(2, 0, 32'h6100_0000);
    collect(0);
    check_pkt(2, "R12");
  endtask

  task automatic t_unmapped_R11;
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'hFFFF_FFFF); wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd9, 32'hFFFF_FFFF); wr(4'd15, 32'hFFFF_FFFF);
    send(2, 0, 32'h7000_0000);
    collect(0);
    check_pkt(2, "R11");
  endtask

  task automatic t_wrap_R8;
    wr(4'd7, 32'd1); wr(4'd8, 32'd1);
    for (int p = 0; p < 17; p++) begin
      send(1, 0, 32'h8000_0000 + 32'(p));
      collect(p % 2);
      check_pkt(1, "R8");
    end
  endtask

  task automatic t_clear_R9;
    wr(4'd3, 32'h0);
    exp_cnt = '0;
    send(1, 0, 32'h9000_0000); collect(0); check_pkt(1, "R9");
    wr(4'd7, 32'd3);
    sent[0] = 32'h9100_0000; push_word(sent[0], 0, 1);
    sent[1] = 32'h9100_0001; push_word(sent[1], 0, 0);
    sent[2] = 32'h9100_0002;
    s_valid = 1'b1; s_data = sent[2]; s_last = 1'b0;
    cfg_we = 1'b1; cfg_addr = 4'd3; cfg_wdata = 32'h0;
    @(negedge clk);
    s_valid = 1'b0; cfg_we = 1'b0;
    collect(0);
    check_pkt(3, "R9");
    exp_cnt = '0;
    send(3, 0, 32'h9200_0000); collect(0); check_pkt(3, "R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_R1;
    t_full_R4;
    t_short_R6;
    t_clamp_R5;
    t_backpressure_R10;
    t_snapshot_R12;
    t_unmapped_R11;
    t_wrap_R8;
    t_clear_R9;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule